// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of a network controller. A frame arrives on a byte stream that marks its final byte. When a frame begins, the engine walks a 16-entry descriptor ring in host memory and looks for an entry that the host has handed to the controller. It copies the frame into that entry's fixed buffer slot. It then writes the received length and a completion status back to the descriptor, and gives a one-cycle receive-done pulse. If no entry is free, the frame is drained and thrown away, and a missed-frame pulse is given instead. A frame that starts while the controller is stopped is drained without touching memory and without any pulse.

Memory is reached through a 16-bit word port. The address is a word address. A request is held until it is acknowledged, and read data is valid in the cycle of the acknowledge. Each descriptor is four words, and descriptor `i` begins at word `ring_base + 4*i`. Word 1 carries the status byte in bits 15:8, and its low byte belongs to the host. Word 3 receives the byte count. The buffer slots follow the descriptors. Slot `i` begins at word `ring_base + 64 + 772*i`, and each slot holds 1544 bytes. Bytes are packed high byte first. A small FIFO takes in the head of a frame while the descriptor search is still running.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After reset, no memory request is made, both pulses are low, the stream input is ready, and the ring pointer is 0, so the first frame goes to entry 0 when that entry is free.
- R2: An entry is free only when its status byte (bits 15:8 of descriptor word 1) equals exactly 0x80. Any other value, including 0x81 or 0x00, causes the entry to be skipped.
- R3: The search examines at most 15 entries in ring order: pointer, pointer+1, and so on up to pointer+14, all taken modulo 16. The entry at pointer-1 is never examined.
- R4: Frame byte `k` is stored in slot word `k/2`. Even `k` goes to bits 15:8 and odd `k` goes to bits 7:0. A frame of odd length writes only the high byte of its last word. No write lands outside the chosen slot and that entry's words 1 and 3.
- R5: Descriptor word 3 is written with the number of bytes stored plus 4.
- R6: The status byte is written last, after the data and the length. It is 0x03 for a frame that fit in the slot. Only bits 15:8 of word 1 are written, so the low byte is kept.
- R7: A frame longer than 1544 bytes is cut to 1544 bytes. Its status byte is 0x53 (0x03 with the error bit 0x40 and the overflow bit 0x10), and its length word is 1548. A frame of exactly 1544 bytes gets status 0x03.
- R8: Each stored frame advances the ring pointer by exactly one, even when a later entry was used, and it wraps from 15 to 0. The receive-done pulse is high for one cycle per stored frame.
- R9: When no free entry is found, the frame is consumed from the stream with no memory write, and the missed-frame pulse is high for one cycle.
- R10: A frame whose first byte arrives while `stopped` is high is consumed with no memory access and no pulse.
- R11: A memory request keeps its address, direction, data and strobes unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stopped | input | 1 | Controller stopped; sampled when a frame starts |
| ring_base | input | 20 | Word address of descriptor 0 |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Engine can take a byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 20 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_wstrb | output | 2 | Byte strobes: bit 1 for bits 15:8, bit 0 for bits 7:0 |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 16 | Read data, valid together with mem_ack |
| rx_done | output | 1 | One-cycle pulse when a frame has been stored |
| rx_missed | output | 1 | One-cycle pulse when a frame was dropped for lack of a free entry |

## Verification
The assertions assume that the memory side acknowledges only a request that is pending, and that it returns the read data in the cycle of the acknowledge. They also assume that `stopped` and `ring_base` change only while no frame is in flight. The bench models host memory as a sparse word array. It acknowledges each request exactly once after a latency of zero to two cycles. It changes descriptors, `stopped` and the base only between frames, after it has seen the previous frame's pulse or a fixed idle gap. Stream bytes are offered at the falling edge and held until they are accepted.

// File: rtl/rxdr_pkg.sv
package rxdr_pkg;
  localparam logic [7:0] ST_BYTE_FREE = 8'h80;
  localparam logic [7:0] ST_BYTE_DONE = 8'h03;
  localparam logic [7:0] ST_BYTE_ERR  = 8'h40;
  localparam logic [7:0] ST_BYTE_OVF  = 8'h10;
  localparam int         FCS_BYTES    = 4;
  localparam int         DESC_WORDS   = 4;
  localparam int         W_STATUS     = 1;
  localparam int         W_COUNT      = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEARCH,
    S_DATA,
    S_LEN,
    S_STAT,
    S_DRAIN
  } rxdr_state_t;
endpackage

// File: rtl/rxdr_fifo.sv
module rxdr_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             not_full,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign not_full  = (cnt_q != CW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign do_push   = push && not_full;
  assign do_pop    = pop && not_empty;
  assign head      = store_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    if (do_push && !do_pop) cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store_q[wr_q] <= push_data;
  end

  // R9: frames are drained by popping, which must never run past the contents
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/rxdr_pack.sv
module rxdr_pack #(
  parameter int SLOT_BYTES = 1544
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  logic                                 clr,
  input  logic                                 in_valid,
  input  logic [7:0]                           in_data,
  input  logic                                 in_last,
  output logic                                 in_pop,
  output logic                                 word_valid,
  output logic [15:0]                          word_data,
  output logic [1:0]                           word_strb,
  output logic [$clog2(SLOT_BYTES/2+1)-1:0]    word_off,
  input  logic                                 word_take,
  output logic                                 frame_end,
  output logic [$clog2(SLOT_BYTES+1)-1:0]      stored,
  output logic                                 ovf
);
  localparam int CW  = $clog2(SLOT_BYTES + 1);
  localparam int OW  = $clog2(SLOT_BYTES / 2 + 1);

  logic [7:0]    hi_q, hi_d;
  logic          have_hi_q, have_hi_d;
  logic [15:0]   wdat_q, wdat_d;
  logic [1:0]    wstb_q, wstb_d;
  logic          wval_q, wval_d;
  logic          end_q, end_d;
  logic          ovf_q, ovf_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [OW-1:0] off_q, off_d;
  logic          take;

  assign in_pop     = en && !end_q && !wval_q && in_valid;
  assign take       = word_take && wval_q;
  assign word_valid = wval_q;
  assign word_data  = wdat_q;
  assign word_strb  = wstb_q;
  assign word_off   = off_q;
  assign frame_end  = end_q && !wval_q;
  assign stored     = cnt_q;
  assign ovf        = ovf_q;

  always_comb begin
    hi_d      = hi_q;
    have_hi_d = have_hi_q;
    wdat_d    = wdat_q;
    wstb_d    = wstb_q;
    wval_d    = wval_q;
    end_d     = end_q;
    ovf_d     = ovf_q;
    cnt_d     = cnt_q;
    off_d     = off_q;
    if (clr) begin
      have_hi_d = 1'b0;
      wval_d    = 1'b0;
      end_d     = 1'b0;
      ovf_d     = 1'b0;
      cnt_d     = '0;
      off_d     = '0;
    end else if (take) begin
      wval_d = 1'b0;
      off_d  = off_q + OW'(1);
    end else if (in_pop) begin
      if (cnt_q < CW'(SLOT_BYTES)) begin
        cnt_d = cnt_q + CW'(1);
        if (!have_hi_q) begin
          if (in_last) begin
            wdat_d = {in_data, 8'h00};
            wstb_d = 2'b10;
            wval_d = 1'b1;
            end_d  = 1'b1;
          end else begin
            hi_d      = in_data;
            have_hi_d = 1'b1;
          end
        end else begin
          wdat_d    = {hi_q, in_data};
          wstb_d    = 2'b11;
          wval_d    = 1'b1;
          have_hi_d = 1'b0;
          end_d     = in_last;
        end
      end else begin
        ovf_d = 1'b1;
        end_d = in_last;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      have_hi_q <= 1'b0;
      wdat_q    <= '0;
      wstb_q    <= '0;
      wval_q    <= 1'b0;
      end_q     <= 1'b0;
      ovf_q     <= 1'b0;
      cnt_q     <= '0;
      off_q     <= '0;
    end else begin
      hi_q      <= hi_d;
      have_hi_q <= have_hi_d;
      wdat_q    <= wdat_d;
      wstb_q    <= wstb_d;
      wval_q    <= wval_d;
      end_q     <= end_d;
      ovf_q     <= ovf_d;
      cnt_q     <= cnt_d;
      off_q     <= off_d;
    end
  end

  a_r7_slot_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SLOT_BYTES));
  a_r4_strobe_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    wval_q |-> wstb_q != 2'b00);
  a_r4_take_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> wval_q);
endmodule

// File: rtl/rxdr_ctrl.sv
module rxdr_ctrl
  import rxdr_pkg::*;
#(
  parameter int AW         = 20,
  parameter int RING       = 16,
  parameter int SLOT_BYTES = 1544
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              stopped,
  input  logic [AW-1:0]                     ring_base,
  input  logic                              fifo_nonempty,
  input  logic                              fifo_last,
  output logic                              drop_pop,
  output logic                              pack_en,
  output logic                              pack_clr,
  input  logic                              word_valid,
  input  logic [15:0]                       word_data,
  input  logic [1:0]                        word_strb,
  input  logic [$clog2(SLOT_BYTES/2+1)-1:0] word_off,
  output logic                              word_take,
  input  logic                              frame_end,
  input  logic [$clog2(SLOT_BYTES+1)-1:0]   stored,
  input  logic                              ovf,
  output logic                              mem_req,
  output logic                              mem_we,
  output logic [AW-1:0]                     mem_addr,
  output logic [15:0]                       mem_wdata,
  output logic [1:0]                        mem_wstrb,
  input  logic                              mem_ack,
  input  logic [15:0]                       mem_rdata,
  output logic                              rx_done,
  output logic                              rx_missed
);
  localparam int IW        = $clog2(RING);
  localparam int SLOTW     = SLOT_BYTES / 2;
  localparam int BUF_START = RING * DESC_WORDS;

  rxdr_state_t st_q, st_d;
  logic [IW-1:0] ptr_q, ptr_d, idx_q, idx_d, seen_q, seen_d, slot_q, slot_d;
  logic          arm_q, arm_d, done_q, done_d, miss_q, miss_d;
  logic [AW-1:0] probe_desc, slot_desc, slot_buf;
  logic [7:0]    fin_status;
  logic          unused_rdata_lo;

  assign unused_rdata_lo = ^mem_rdata[7:0];
  assign probe_desc = ring_base + (AW'(idx_q) << 2);
  assign slot_desc  = ring_base + (AW'(slot_q) << 2);
  assign slot_buf   = ring_base + AW'(BUF_START) + AW'(slot_q) * AW'(SLOTW) + AW'(word_off);
  assign fin_status = ovf ? (ST_BYTE_DONE | ST_BYTE_ERR | ST_BYTE_OVF) : ST_BYTE_DONE;

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    idx_d     = idx_q;
    seen_d    = seen_q;
    slot_d    = slot_q;
    arm_d     = arm_q;
    done_d    = 1'b0;
    miss_d    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wstrb = '0;
    drop_pop  = 1'b0;
    pack_en   = 1'b0;
    pack_clr  = 1'b0;
    word_take = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (fifo_nonempty) begin
          if (stopped) begin
            st_d  = S_DRAIN;
            arm_d = 1'b0;
          end else begin
            st_d   = S_SEARCH;
            idx_d  = ptr_q;
            seen_d = '0;
          end
        end
      end
      S_SEARCH: begin
        mem_req  = 1'b1;
        mem_addr = probe_desc + AW'(W_STATUS);
        if (mem_ack) begin
          if (mem_rdata[15:8] == ST_BYTE_FREE) begin
            slot_d = idx_q;
            st_d   = S_DATA;
          end else if (seen_q == IW'(RING - 2)) begin
            st_d  = S_DRAIN;
            arm_d = 1'b1;
          end else begin
            idx_d  = idx_q + IW'(1);
            seen_d = seen_q + IW'(1);
          end
        end
      end
      S_DATA: begin
        pack_en = 1'b1;
        if (word_valid) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = slot_buf;
          mem_wdata = word_data;
          mem_wstrb = word_strb;
          word_take = mem_ack;
        end else if (frame_end) begin
          st_d = S_LEN;
        end
      end
      S_LEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = slot_desc + AW'(W_COUNT);
        mem_wdata = 16'(stored) + 16'(FCS_BYTES);
        mem_wstrb = 2'b11;
        if (mem_ack) st_d = S_STAT;
      end
      S_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = slot_desc + AW'(W_STATUS);
        mem_wdata = {fin_status, 8'h00};
        mem_wstrb = 2'b10;
        if (mem_ack) begin
          st_d     = S_IDLE;
          ptr_d    = ptr_q + IW'(1);
          done_d   = 1'b1;
          pack_clr = 1'b1;
        end
      end
      S_DRAIN: begin
        if (fifo_nonempty) begin
          drop_pop = 1'b1;
          if (fifo_last) begin
            st_d   = S_IDLE;
            miss_d = arm_q;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ptr_q  <= '0;
      idx_q  <= '0;
      seen_q <= '0;
      slot_q <= '0;
      arm_q  <= 1'b0;
      done_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      idx_q  <= idx_d;
      seen_q <= seen_d;
      slot_q <= slot_d;
      arm_q  <= arm_d;
      done_q <= done_d;
      miss_q <= miss_d;
    end
  end

  assign rx_done   = done_q;
  assign rx_missed = miss_q;

  a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata) && $stable(mem_wstrb));
  a_r8_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ptr_q == $past(ptr_q) + IW'(1));
  a_r8_pointer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> ptr_q == $past(ptr_q));
  a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_missed));
endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer #(
  parameter int AW         = 20,
  parameter int RING       = 16,
  parameter int SLOT_BYTES = 1544,
  parameter int FIFO_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stopped,
  input  logic [AW-1:0] ring_base,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic [1:0]    mem_wstrb,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          rx_done,
  output logic          rx_missed
);
  localparam int CW = $clog2(SLOT_BYTES + 1);
  localparam int OW = $clog2(SLOT_BYTES / 2 + 1);

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  logic [8:0]    head;
  logic          f_nonempty, drop_pop, pack_pop, pack_en, pack_clr;
  logic          w_valid, w_take, f_end, p_ovf;
  logic [15:0]   w_data;
  logic [1:0]    w_strb;
  logic [OW-1:0] w_off;
  logic [CW-1:0] p_stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  rxdr_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(9)) u_fifo (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .push      (in_valid),
    .push_data ({in_last, in_data}),
    .not_full  (in_ready),
    .pop       (drop_pop | pack_pop),
    .head      (head),
    .not_empty (f_nonempty)
  );

  rxdr_pack #(.SLOT_BYTES(SLOT_BYTES)) u_pack (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .en         (pack_en),
    .clr        (pack_clr),
    .in_valid   (f_nonempty),
    .in_data    (head[7:0]),
    .in_last    (head[8]),
    .in_pop     (pack_pop),
    .word_valid (w_valid),
    .word_data  (w_data),
    .word_strb  (w_strb),
    .word_off   (w_off),
    .word_take  (w_take),
    .frame_end  (f_end),
    .stored     (p_stored),
    .ovf        (p_ovf)
  );

  rxdr_ctrl #(.AW(AW), .RING(RING), .SLOT_BYTES(SLOT_BYTES)) u_ctrl (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .stopped       (stopped),
    .ring_base     (ring_base),
    .fifo_nonempty (f_nonempty),
    .fifo_last     (head[8]),
    .drop_pop      (drop_pop),
    .pack_en       (pack_en),
    .pack_clr      (pack_clr),
    .word_valid    (w_valid),
    .word_data     (w_data),
    .word_strb     (w_strb),
    .word_off      (w_off),
    .word_take     (w_take),
    .frame_end     (f_end),
    .stored        (p_stored),
    .ovf           (p_ovf),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_wstrb     (mem_wstrb),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .rx_done       (rx_done),
    .rx_missed     (rx_missed)
  );

  a_r10_single_popper: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(drop_pop && pack_pop));
endmodule

// File: tb/rx_desc_ring_writer_bench.sv
module rx_desc_ring_writer_bench;
  localparam int AW    = 20;
  localparam int RING  = 16;
  localparam int SLOT  = 1544;
  localparam int SLOTW = SLOT / 2;
  localparam int BASE  = 'h1000;
  localparam int BUFB  = BASE + RING * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stopped = 1'b0;
  logic [AW-1:0] ring_base = AW'(BASE);
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_last = 1'b0;
  logic          in_ready;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [1:0]    mem_wstrb;
  logic          mem_ack = 1'b0;
  logic [15:0]   mem_rdata = 16'h0000;
  logic          rx_done, rx_missed;

  always #10 clk = ~clk;

  rx_desc_ring_writer u_rx_desc_ring_writer (
    .clk(clk), .rst_n(rst_n), .stopped(stopped), .ring_base(ring_base),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rx_done(rx_done), .rx_missed(rx_missed)
  );

  logic [15:0] mem [int];
  int checks = 0, fails = 0;
  int ptr_m = 0;
  int cur_slot = -1;
  string cur_req = "R4";
  int wr_cnt = 0, done_cnt = 0, miss_cnt = 0;
  int lat_sel = 0, wcnt = 0, cyc = 0;
  bit pend = 1'b0;
  logic [AW-1:0] pend_addr = '0;

  function automatic logic [15:0] rdm(int a);
    if (mem.exists(a)) return mem[a];
    return 16'h0000;
  endfunction

  function automatic int desc(int i);
    return BASE + 4 * i;
  endfunction

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 37 + k * 5 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // host memory model and per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_done) done_cnt++;
      if (rx_missed) miss_cnt++;
      if (pend)
        chk(mem_req && mem_addr == pend_addr, "R11", "request dropped or moved",
            int'(mem_addr), int'(pend_addr));
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt >= lat_sel % 3) begin
          if (mem_we) begin
            int a;
            logic [15:0] w;
            bit ok;
            a = int'(mem_addr);
            wr_cnt++;
            ok = cur_slot >= 0 &&
                 ((a >= BUFB + cur_slot * SLOTW && a < BUFB + (cur_slot + 1) * SLOTW) ||
                  a == desc(cur_slot) + 1 || a == desc(cur_slot) + 3);
            chk(ok, cur_req, "write outside expected region", a, cur_slot);
            w = rdm(a);
            if (mem_wstrb[1]) w[15:8] = mem_wdata[15:8];
            if (mem_wstrb[0]) w[7:0] = mem_wdata[7:0];
            mem[a] = w;
          end else begin
            mem_rdata = rdm(int'(mem_addr));
          end
          mem_ack = 1'b1;
          lat_sel++;
        end else begin
          wcnt++;
        end
      end
      pend = mem_req && !mem_ack;
      pend_addr = mem_addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send(int len, int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pat(seed, k);
      in_last  = (k == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_frame(int len, int seed, bit stop, string tag);
    int slot;
    int stored;
    logic [15:0] w;
    logic [7:0] lo;
    slot = -1;
    lo = 8'h00;
    if (!stop)
      for (int n = 0; n < RING - 1; n++) begin
        int i;
        i = (ptr_m + n) % RING;
        w = rdm(desc(i) + 1);
        if (slot < 0 && w[15:8] == 8'h80) slot = i;
      end
    stored   = (len > SLOT) ? SLOT : len;
    cur_slot = slot;
    cur_req  = stop ? "R10" : (slot < 0 ? "R9" : "R4");
    if (slot >= 0) begin
      w = rdm(desc(slot) + 1);
      lo = w[7:0];
      if (stored % 2 == 1) mem[BUFB + slot * SLOTW + stored / 2] = 16'hEEEE;
    end
    wr_cnt = 0; done_cnt = 0; miss_cnt = 0;
    stopped = stop;
    send(len, seed);
    stopped = 1'b0;
    if (stop || slot < 0) repeat (60) @(negedge clk);
    else
      for (int t = 0; t < 8000; t++) begin
        @(negedge clk);
        if (done_cnt + miss_cnt > 0) break;
      end
    repeat (5) @(negedge clk);
    if (stop) begin
      chk(wr_cnt == 0, "R10", {tag, " writes while stopped"}, wr_cnt, 0);
      chk(done_cnt == 0 && miss_cnt == 0, "R10", {tag, " pulses while stopped"},
          done_cnt + miss_cnt, 0);
    end else if (slot < 0) begin
      chk(wr_cnt == 0, "R9", {tag, " writes on miss"}, wr_cnt, 0);
      chk(miss_cnt == 1, "R9", {tag, " missed pulse count"}, miss_cnt, 1);
      chk(done_cnt == 0, "R9", {tag, " done on miss"}, done_cnt, 0);
    end else begin
      int bad;
      bad = 0;
      for (int k = 0; k < stored; k++) begin
        logic [7:0] b;
        w = rdm(BUFB + slot * SLOTW + k / 2);
        b = (k % 2 == 1) ? w[7:0] : w[15:8];
        if (b != pat(seed, k)) bad++;
      end
      chk(bad == 0, "R4", {tag, " stored bytes in slot"}, bad, 0);
      if (stored % 2 == 1) begin
        w = rdm(BUFB + slot * SLOTW + stored / 2);
        chk(w[7:0] == 8'hEE, "R4", {tag, " odd tail low byte kept"}, w[7:0], 8'hEE);
      end
      w = rdm(desc(slot) + 3);
      chk(int'(w) == stored + 4, "R5", {tag, " length word"}, w, stored + 4);
      w = rdm(desc(slot) + 1);
      if (len > SLOT)
        chk(w[15:8] == 8'h53, "R7", {tag, " truncated status"}, w[15:8], 8'h53);
      else
        chk(w[15:8] == 8'h03, "R6", {tag, " status byte"}, w[15:8], 8'h03);
      chk(w[7:0] == lo, "R6", {tag, " status low byte kept"}, w[7:0], lo);
      chk(done_cnt == 1 && miss_cnt == 0, "R8", {tag, " done pulse count"}, done_cnt, 1);
      ptr_m = (ptr_m + 1) % RING;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    begin
      int q;
      q = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (mem_req || rx_done || rx_missed || !in_ready) q++;
      end
      chk(q == 0, "R1", "idle after reset", q, 0);
    end
    for (int i = 0; i < RING; i++) mem[desc(i) + 1] = 16'h805A;
    run_frame(10, 1, 1'b0, "R1 first frame to entry zero");
    run_frame(7, 2, 1'b0, "R4 odd length");
    mem[desc(2) + 1] = 16'h8100;
    mem[desc(3) + 1] = 16'h0000;
    run_frame(20, 3, 1'b0, "R2 skip non-exact owner");
    run_frame(4, 4, 1'b0, "R8 pointer steps by one");
    for (int i = 0; i < RING; i++) mem[desc(i) + 1] = 16'h0000;
    mem[desc((ptr_m + RING - 1) % RING) + 1] = 16'h8000;
    run_frame(12, 5, 1'b0, "R3 entry before pointer unseen");
    mem[desc(ptr_m) + 1] = 16'h8011;
    run_frame(9, 6, 1'b1, "R10 stopped");
    run_frame(1, 7, 1'b0, "R4 single byte");
    mem[desc(ptr_m) + 1] = 16'h80A5;
    run_frame(1550, 8, 1'b0, "R7 overflow");
    mem[desc(ptr_m) + 1] = 16'h8000;
    run_frame(SLOT, 9, 1'b0, "R7 exact slot size");
    mem[desc(ptr_m) + 1] = 16'h8000;
    run_frame(2, 10, 1'b0, "R5 two bytes");
    run_frame(6, 11, 1'b0, "R9 ring exhausted");
    for (int i = 0; i < RING; i++) mem[desc(i) + 1] = 16'h80C3;
    for (int f = 0; f < 10; f++) run_frame(3 + f, 20 + f, 1'b0, "R8 wrap");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule